// File: doc/BRIEF.md
# 2B+D Time-Slot Loopback Steering Controller

This block sits between the interchip serial port and the line-side transmit/receive path of a basic-rate line transceiver. Once per frame it takes the two bearer channels and the signalling channel from both the interchip receive side and the line receive side. It then decides what goes out on the interchip transmit side and on the line transmit path. Each channel can carry normal traffic, or it can be turned straight back toward the interchip port. While any loop is active, the line transmit path either still gets the interchip data, or it is held at all ones (idle).

Channels are presented frame-parallel, one whole frame per frame-sync strobe. The frame vector has B1 in bits [17:10], B2 in bits [9:2] and D in bits [1:0]. A small register bank holds the loop selects, a return-to-normal bit and a CRC-corrupt control bit. Both outputs are registered on the frame-sync cycle, so every frame leaves with one consistent setting.

Top module: `lbk_2bd_loopback`

## Requirements
- R1: After reset both frame outputs are all ones, every register reads 0 and `crc_corrupt` is 0.
- R2: Address 0 holds the loop control: bit 0 transparent, bit 1 full 2B+D loop, bit 2 B2 loop, bit 3 B1 loop. Bits 7:4 are ignored and read 0. Address 1 holds bit 0 return-to-normal and bit 1 CRC-corrupt, which drives `crc_corrupt`.
- R3: With the B1 loop set and full loop clear, interchip transmit bits [17:10] equal the interchip receive bits [17:10] of the same frame.
- R4: With the B2 loop set and full loop clear, interchip transmit bits [9:2] equal the interchip receive bits [9:2] of the same frame.
- R5: With the full loop set, all 18 interchip transmit bits equal the interchip receive frame, whatever the B1 and B2 loop bits are.
- R6: A channel that is not looped carries line receive data to the interchip transmit output. With no loop bit set (bits 3:1 all 0), the line transmit frame equals the interchip receive frame.
- R7: With any loop active and transparent set, the line transmit frame equals the interchip receive frame.
- R8: With any loop active and transparent clear, the line transmit frame is all ones.
- R9: Outputs change only on a frame-sync cycle, using the control value present in that cycle. They show the result from the next cycle and hold it until the next strobe.
- R10: A 1-to-0 change of return-to-normal raises a clear for exactly one clock. That clear zeroes the loop control and CRC-corrupt bits. Writing return-to-normal to 1 alone clears nothing.
- R11: Writing a loop bit back to 0 ends that loop from the next frame on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame strobe, one cycle per frame |
| port_rx | input | 18 | Interchip receive frame {B1,B2,D} |
| line_rx | input | 18 | Line receive frame {B1,B2,D} |
| port_tx | output | 18 | Interchip transmit frame |
| line_tx | output | 18 | Line transmit frame |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 1 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| crc_corrupt | output | 1 | CRC-corrupt control bit |

## Verification
The hardest state to reach from the ports is the clear itself. It needs a two-write sequence, and its effect appears one cycle after the second write. The stimulus first leaves return-to-normal at 1 and checks that the loop bits and CRC-corrupt bit survive. It then writes 0, waits the clear cycle, and reads both registers back and runs a frame to show that normal steering is back. Randomly chosen control words mix the B1, B2 and full loop bits so that the override of the full loop is met with every combination of the per-channel bits.

// File: rtl/lbk_pkg.sv
package lbk_pkg;
   localparam int B_W_DEF   = 8;
   localparam int D_W_DEF   = 2;
   localparam int REG_W_DEF = 8;
   localparam int CH_NUM    = 3;
   // control bit positions (decoded by steering)
   localparam int BIT_TRANSP = 0;
   localparam int BIT_FULL   = 1;
   localparam int BIT_LB2    = 2;
   localparam int BIT_LB1    = 3;
   localparam int CTL_W      = 4;
   typedef struct packed {
      logic lb1;
      logic lb2;
      logic full;
      logic transp;
   } lbk_cfg_t;
endpackage

// File: rtl/lbk_ctl_regs.sv
module lbk_ctl_regs #(
   parameter int REG_W  = 8,
   parameter int ADDR_W = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [REG_W-1:0]  rd_data,
   output lbk_pkg::lbk_cfg_t cfg,
   output logic              crc_bit
);
   import lbk_pkg::*;

   if (REG_W < CTL_W) begin : g_bad_w
      $error("REG_W too small for the control field");
   end

   logic [CTL_W-1:0] ctl_q;
   logic             rtn_q;
   logic             rtn_prev_q;
   logic             crc_q;
   logic             clr;
   logic             wr_ctl;
   logic             wr_misc;

   assign wr_ctl  = wr_en && (wr_addr == ADDR_W'(0));
   assign wr_misc = wr_en && (wr_addr == ADDR_W'(1));
   assign clr     = rtn_prev_q & ~rtn_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ctl_q      <= '0;
         rtn_q      <= 1'b0;
         rtn_prev_q <= 1'b0;
         crc_q      <= 1'b0;
      end else begin
         rtn_prev_q <= rtn_q;
         if (wr_misc) rtn_q <= wr_data[0];
         if (clr) begin
            ctl_q <= '0;
            crc_q <= 1'b0;
         end else begin
            if (wr_ctl)  ctl_q <= wr_data[CTL_W-1:0];
            if (wr_misc) crc_q <= wr_data[1];
         end
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(0)) rd_data[CTL_W-1:0] = ctl_q;
      else if (rd_addr == ADDR_W'(1)) begin
         rd_data[0] = rtn_q;
         rd_data[1] = crc_q;
      end
   end

   assign cfg.lb1    = ctl_q[BIT_LB1];
   assign cfg.lb2    = ctl_q[BIT_LB2];
   assign cfg.full   = ctl_q[BIT_FULL];
   assign cfg.transp = ctl_q[BIT_TRANSP];
   assign crc_bit    = crc_q;

   // R10
   clr_wipes_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(rtn_q) |=> (ctl_q == '0) && !crc_q);
   // R10
   clr_single_chk: assert property (@(posedge clk) disable iff (rst)
      clr |=> !clr);
endmodule

// File: rtl/lbk_chan_steer.sv
module lbk_chan_steer #(
   parameter int W = 8
) (
   input  logic         loop_sel,
   input  logic         line_idle,
   input  logic [W-1:0] port_rx,
   input  logic [W-1:0] line_rx,
   output logic [W-1:0] port_tx_d,
   output logic [W-1:0] line_tx_d
);
   if (W < 1) begin : g_bad_w
      $error("channel width must be positive");
   end

   assign port_tx_d = loop_sel  ? port_rx : line_rx;
   assign line_tx_d = line_idle ? {W{1'b1}} : port_rx;
endmodule

// File: rtl/lbk_frame_reg.sv
module lbk_frame_reg #(
   parameter int W = 18
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         fsync,
   input  logic [W-1:0] port_d,
   input  logic [W-1:0] line_d,
   output logic [W-1:0] port_q,
   output logic [W-1:0] line_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         port_q <= '1;
         line_q <= '1;
      end else if (fsync) begin
         port_q <= port_d;
         line_q <= line_d;
      end
   end

   // R9
   hold_port_chk: assert property (@(posedge clk) disable iff (rst)
      !fsync |=> $stable(port_q));
   // R9
   hold_line_chk: assert property (@(posedge clk) disable iff (rst)
      !fsync |=> $stable(line_q));
endmodule

// File: rtl/lbk_2bd_loopback.sv
module lbk_2bd_loopback #(
   parameter int B_W    = lbk_pkg::B_W_DEF,
   parameter int D_W    = lbk_pkg::D_W_DEF,
   parameter int REG_W  = lbk_pkg::REG_W_DEF,
   parameter int ADDR_W = 1,
   localparam int FR_W  = 2*B_W + D_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              fsync,
   input  logic [FR_W-1:0]   port_rx,
   input  logic [FR_W-1:0]   line_rx,
   output logic [FR_W-1:0]   port_tx,
   output logic [FR_W-1:0]   line_tx,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [REG_W-1:0]  rd_data,
   output logic              crc_corrupt
);
   import lbk_pkg::*;

   if (ADDR_W < 1) begin : g_bad_a
      $error("ADDR_W must be at least 1");
   end

   lbk_cfg_t        cfg;
   logic            any_loop;
   logic            idle_line;
   logic [FR_W-1:0] port_d;
   logic [FR_W-1:0] line_d;

   lbk_ctl_regs #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .cfg(cfg), .crc_bit(crc_corrupt)
   );

   assign any_loop  = cfg.full | cfg.lb1 | cfg.lb2;
   assign idle_line = any_loop & ~cfg.transp;

   // channel 0 = D (low bits), 1 = B2, 2 = B1 (high bits)
   for (genvar c = 0; c < CH_NUM; c++) begin : g_ch
      localparam int W  = (c == 0) ? D_W : B_W;
      localparam int LO = (c == 0) ? 0 : (c == 1) ? D_W : D_W + B_W;
      logic sel;
      if (c == 0) begin : g_d
         assign sel = cfg.full;
      end else if (c == 1) begin : g_b2
         assign sel = cfg.full | cfg.lb2;
      end else begin : g_b1
         assign sel = cfg.full | cfg.lb1;
      end
      lbk_chan_steer #(.W(W)) u_steer (
         .loop_sel(sel), .line_idle(idle_line),
         .port_rx(port_rx[LO +: W]), .line_rx(line_rx[LO +: W]),
         .port_tx_d(port_d[LO +: W]), .line_tx_d(line_d[LO +: W])
      );
   end

   lbk_frame_reg #(.W(FR_W)) u_out (
      .clk(clk), .rst(rst), .fsync(fsync),
      .port_d(port_d), .line_d(line_d),
      .port_q(port_tx), .line_q(line_tx)
   );

   // R5
   full_loop_chk: assert property (@(posedge clk) disable iff (rst)
      (fsync && cfg.full) |=> (port_tx == $past(port_rx)));
   // R8
   idle_ones_chk: assert property (@(posedge clk) disable iff (rst)
      (fsync && any_loop && !cfg.transp) |=> (line_tx == '1));
   // R6
   normal_line_chk: assert property (@(posedge clk) disable iff (rst)
      (fsync && !any_loop) |=> (line_tx == $past(port_rx)));
endmodule

// File: tb/lbk_2bd_loopback_tb.sv
`timescale 1ns/1ps
module lbk_2bd_loopback_tb;
   logic        clk = 1'b0;
   logic        rst;
   logic        fsync;
   logic [17:0] port_rx, line_rx, port_tx, line_tx;
   logic        wr_en;
   logic [0:0]  wr_addr, rd_addr;
   logic [7:0]  wr_data, rd_data;
   logic        crc_corrupt;
   int          total = 0;
   int          bad = 0;
   logic [3:0]  cur_ctl;

   always #2.5 clk = ~clk;

   lbk_2bd_loopback u_dut (
      .clk(clk), .rst(rst), .fsync(fsync), .port_rx(port_rx), .line_rx(line_rx),
      .port_tx(port_tx), .line_tx(line_tx), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .crc_corrupt(crc_corrupt)
   );

   function automatic logic [17:0] exp_port(logic [3:0] c, logic [17:0] p, logic [17:0] l);
      logic [17:0] r;
      r = l;
      if (c[1]) r = p;
      else begin
         if (c[3]) r[17:10] = p[17:10];
         if (c[2]) r[9:2]   = p[9:2];
      end
      return r;
   endfunction

   function automatic logic [17:0] exp_line(logic [3:0] c, logic [17:0] p);
      if ((|c[3:1]) && !c[0]) return '1;
      return p;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(logic a, logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic rd(logic a, string req, logic [7:0] exp);
      rd_addr = a; #0.5;
      check(req, rd_data, exp);
   endtask

   task automatic frame(logic [17:0] p, logic [17:0] l);
      port_rx = p; line_rx = l; fsync = 1'b1;
      @(posedge clk); #1;
      fsync = 1'b0;
      @(negedge clk);
   endtask

   task automatic frame_chk(logic [17:0] p, logic [17:0] l, string rp, string rl);
      frame(p, l);
      check(rp, port_tx, exp_port(cur_ctl, p, l));
      check(rl, line_tx, exp_line(cur_ctl, p));
   endtask

   task automatic set_ctl(logic [7:0] d);
      wr(1'b0, d);
      cur_ctl = d[3:0];
   endtask

   initial begin
      #(5.0 * 150000);
      bad++; total++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int unsigned seed;
      logic [17:0] p, l, hp, hl;
      logic [3:0]  c;
      seed = 32'd4242;
      void'($urandom(seed));
      rst = 1'b1; fsync = 0; port_rx = 0; line_rx = 0;
      wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0; cur_ctl = 0;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);

      // R1 reset state
      check("R1", port_tx, 18'h3ffff);
      check("R1", line_tx, 18'h3ffff);
      rd(1'b0, "R1", 8'h00);
      rd(1'b1, "R1", 8'h00);
      check("R1", crc_corrupt, 0);

      // R2 register layout, upper bits ignored, crc bit to port
      set_ctl(8'hF5);
      cur_ctl = 4'h5;
      rd(1'b0, "R2", 8'h05);
      wr(1'b1, 8'h02);
      rd(1'b1, "R2", 8'h02);
      check("R2", crc_corrupt, 1);
      wr(1'b1, 8'h00);
      @(negedge clk);
      check("R2", crc_corrupt, 0);

      // R6 no loop
      set_ctl(8'h00);
      frame_chk(18'h2a5c3, 18'h15a3c, "R6", "R6");
      // R3 B1 loop, idle line
      set_ctl(8'h08);
      frame_chk(18'h3c0f1, 18'h0f3c2, "R3", "R8");
      // R4 B2 loop, transparent
      set_ctl(8'h05);
      frame_chk(18'h12345, 18'h2abcd, "R4", "R7");
      // R5 full loop overrides per-channel bits
      set_ctl(8'h0E);
      frame_chk(18'h00003, 18'h3fffc, "R5", "R8");
      set_ctl(8'h03);
      frame_chk(18'h1f0e1, 18'h20f1e, "R5", "R7");

      // R9 outputs hold without strobe; ctl write between strobes waits
      hp = port_tx; hl = line_tx;
      port_rx = 18'h0; line_rx = 18'h3ffff;
      set_ctl(8'h00);
      repeat (3) @(negedge clk);
      check("R9", port_tx, hp);
      check("R9", line_tx, hl);
      frame_chk(18'h11111, 18'h22222, "R9", "R9");

      // R11 clearing a bit ends its loop next frame
      set_ctl(8'h08);
      frame_chk(18'h3aaaa, 18'h05555, "R11", "R11");
      set_ctl(8'h00);
      frame_chk(18'h3aaaa, 18'h05555, "R11", "R11");

      // R10 return-to-normal
      set_ctl(8'h0B);
      wr(1'b1, 8'h03);
      @(negedge clk);
      rd(1'b0, "R10", 8'h0B);
      check("R10", crc_corrupt, 1);
      wr(1'b1, 8'h00);
      @(negedge clk);
      rd(1'b0, "R10", 8'h00);
      rd(1'b1, "R10", 8'h00);
      check("R10", crc_corrupt, 0);
      cur_ctl = 4'h0;
      frame_chk(18'h0c0c0, 18'h30303, "R10", "R10");

      // random mix
      for (int i = 0; i < 300; i++) begin
         string tp, tl;
         c = 4'($urandom());
         set_ctl({4'($urandom()), c});
         p = 18'($urandom()); l = 18'($urandom());
         tp = c[1] ? "R5" : c[3] ? "R3" : c[2] ? "R4" : "R6";
         tl = (|c[3:1]) ? (c[0] ? "R7" : "R8") : "R6";
         frame_chk(p, l, tp, tl);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule